// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous 512-row DRAM alive. Out of reset it holds the strobes idle for a power-up delay. It then runs a burst of initialization refresh cycles on its own, with no grant needed, and raises `init_done`. From then on an interval timer marks each slice of the retention period and leaves one owed refresh. A request line stays high while refreshes are owed. When the memory arbiter grants it, the block drives a CAS-before-RAS cycle on its own strobes and then pulses `refresh_done`. In this cycle style the DRAM supplies the row from an internal counter, so the block has no address output.

Only the strobes are driven here. Data, access addressing and the other memory controls belong to the arbiter's other clients. A self-refresh request uses the same handshake. After the grant, both strobes drop and stay low for at least the minimum hold time, and for as long as the request remains high. The exit precharge is longer than the normal one. Because the memory refreshed itself while in that state, any refreshes still owed are discarded.

All durations are parameters counted in clock cycles. The defaults suit a 100 MHz clock: power-up 20000, interval 1560, CAS lead 1, RAS low 6, precharge 4, self-refresh hold 10000, exit precharge 11. These give 110 ns per refresh cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and right after reset, `ras_n` and `cas_n` are high, `refresh_req` and `init_done` are low and `busy` is high. The first fall of `cas_n` comes PWRUP_CYC clock cycles after reset is released.
- R2: After the power-up wait, exactly INIT_CNT refresh cycles run back to back without any grant, and then `init_done` rises. `refresh_req` never rises before `init_done`.
- R3: In every cycle `cas_n` falls first, and stays low alone for T_CSR clock cycles before `ras_n` falls. `cas_n` stays low for as long as `ras_n` is low.
- R4: In a normal refresh `ras_n` is low for exactly T_RAS cycles. A precharge of exactly T_RP cycles follows, with both strobes high, before the block goes idle or starts another cycle.
- R5: After `init_done`, one refresh becomes owed every INTERVAL_CYC cycles. `refresh_req` then stays high until it is granted.
- R6: A `refresh_gnt` pulse while `refresh_req` is low has no effect: the strobes stay high and `busy` stays low.
- R7: Owed refreshes are counted up to BL_MAX. Each granted normal refresh serves one of them, and `refresh_req` falls once none are left. Interval expiries beyond BL_MAX are lost.
- R8: `busy` rises in the cycle after an accepted grant and stays high through the precharge. `refresh_done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: When `self_req` is high at the grant, the cycle enters self-refresh: `cas_n` leads as in R3, and `self_active` is high while both strobes stay low. The low phase lasts at least T_SELF cycles and ends in the cycle after `self_req` is seen low once T_SELF has elapsed.
- R10: Leaving self-refresh runs a precharge of exactly T_RPS cycles, clears every owed refresh, restarts the interval timer, and pulses `refresh_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_req | input | 1 | Request to enter and stay in self-refresh |
| refresh_gnt | input | 1 | Arbiter grant; accepted only while `refresh_req` is high |
| refresh_req | output | 1 | A refresh or self-refresh is waiting for a grant |
| refresh_done | output | 1 | One-cycle pulse when a granted cycle has finished |
| busy | output | 1 | Strobes are in use; memory not available to other clients |
| init_done | output | 1 | Power-up wait and initialization burst are complete |
| self_active | output | 1 | DRAM is held in self-refresh |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low, both byte lanes |

## Verification
The assertions assume that every timing parameter is at least one cycle. They also assume that `self_req` does not change between the cycle it raises a request and the grant, because the kind of cycle is latched at acceptance. The bench changes inputs only on falling clock edges. It raises `refresh_gnt` for a single cycle, and only after it has seen `refresh_req` high, except in the one deliberate test of a stray grant. It holds `self_req` steady from the request through the grant.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_CSR, ST_RASLO, ST_SELF, ST_PRE
  } rf_state_e;

  // Down-counter load value for a phase lasting n cycles.
  function automatic int unsigned rf_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned rf_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned rf_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Saturating owed-refresh bookkeeping: up = interval expiry, dn = grant served.
  function automatic int unsigned rf_backlog_next(input int unsigned cur, input bit up,
                                                  input bit dn, input int unsigned cap);
    if (up && !dn) return (cur < cap) ? cur + 1 : cur;
    if (dn && !up) return (cur > 0) ? cur - 1 : 0;
    return cur;
  endfunction

endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned BL_MAX       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  input  logic clear,
  output logic owed
);
  localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned BW = $clog2(BL_MAX + 1);
  localparam logic [TW-1:0] TLOAD = TW'(rf_load(INTERVAL_CYC));

  logic [TW-1:0] tcnt;
  logic [BW-1:0] backlog;
  logic          tick;

  assign tick = run && !clear && (tcnt == '0);
  assign owed = (backlog != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= TLOAD;
      backlog <= '0;
    end else begin
      if (clear || !run || tcnt == '0) tcnt <= TLOAD;
      else                              tcnt <= tcnt - 1'b1;
      if (clear) backlog <= '0;
      else backlog <= BW'(rf_backlog_next(int'(backlog), tick, take, BL_MAX));
    end
  end

  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(BL_MAX));
  a_r7_take_owed: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> backlog != '0);
  a_r5_tick_owes: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> backlog != '0);
endmodule

// File: rtl/rf_cycle_fsm.sv
module rf_cycle_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned INIT_CNT  = 8,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_SELF    = 10000,
  parameter int unsigned T_RPS     = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic self_req,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done,
  output logic init_done,
  output logic self_active,
  output logic self_exit
);
  localparam int unsigned MAXT = rf_max(rf_max(PWRUP_CYC, T_SELF),
                                        rf_max(rf_max(T_CSR, T_RAS), rf_max(T_RP, T_RPS)));
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam int unsigned IW   = $clog2(INIT_CNT + 1);
  localparam int unsigned MIN_LO  = rf_min(T_RAS, T_SELF);
  localparam int unsigned MIN_PRE = rf_min(T_RP, T_RPS);

  rf_state_e     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [IW-1:0] init_left;
  logic          init_q, self_q, ras_q, cas_q, done_q;
  logic          pre_end;

  assign pre_end   = (st == ST_PRE) && (cnt == '0);
  assign self_exit = (st == ST_SELF) && (cnt == '0) && !self_req;

  always_comb begin
    st_n  = st;
    cnt_n = (cnt != '0) ? cnt - 1'b1 : '0;
    case (st)
      ST_PWRUP: if (cnt == '0) begin st_n = ST_CSR; cnt_n = CW'(rf_load(T_CSR)); end
      ST_IDLE:  if (start)     begin st_n = ST_CSR; cnt_n = CW'(rf_load(T_CSR)); end
      ST_CSR:   if (cnt == '0) begin
                  if (self_q) begin st_n = ST_SELF;  cnt_n = CW'(rf_load(T_SELF)); end
                  else        begin st_n = ST_RASLO; cnt_n = CW'(rf_load(T_RAS));  end
                end
      ST_RASLO: if (cnt == '0) begin st_n = ST_PRE; cnt_n = CW'(rf_load(T_RP)); end
      ST_SELF:  if (self_exit) begin st_n = ST_PRE; cnt_n = CW'(rf_load(T_RPS)); end
      ST_PRE:   if (pre_end) begin
                  if (!init_q && init_left != IW'(1)) begin
                    st_n = ST_CSR; cnt_n = CW'(rf_load(T_CSR));
                  end else st_n = ST_IDLE;
                end
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWRUP;
      cnt       <= CW'(rf_load(PWRUP_CYC));
      init_left <= IW'(INIT_CNT);
      init_q    <= 1'b0;
      self_q    <= 1'b0;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      ras_q  <= !(st_n == ST_RASLO || st_n == ST_SELF);
      cas_q  <= !(st_n == ST_CSR || st_n == ST_RASLO || st_n == ST_SELF);
      done_q <= pre_end && init_q;
      if (start) self_q <= self_req;
      if (pre_end && !init_q) begin
        init_left <= init_left - 1'b1;
        if (init_left == IW'(1)) init_q <= 1'b1;
      end
    end
  end

  assign ras_n       = ras_q;
  assign cas_n       = cas_q;
  assign busy        = (st != ST_IDLE);
  assign done        = done_q;
  assign init_done   = init_q;
  assign self_active = (st == ST_SELF);

  // Phase-length observers for the timing assertions.
  logic [CW-1:0] lo_len, hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '0;
    end else begin
      lo_len <= !ras_q ? ((lo_len == '1) ? lo_len : lo_len + 1'b1) : '0;
      hi_len <=  ras_q ? ((hi_len == '1) ? hi_len : hi_len + 1'b1) : '0;
    end
  end

  a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> $past(!cas_q));
  a_r3_cas_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_q |-> !cas_q);
  a_r4_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_q) |-> lo_len >= CW'(MIN_LO));
  a_r4_pre_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_q) |-> hi_len >= CW'(MIN_PRE));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned BL_MAX       = 8,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_SELF       = 10000,
  parameter int unsigned T_RPS        = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic self_req,
  input  logic refresh_gnt,
  output logic refresh_req,
  output logic refresh_done,
  output logic busy,
  output logic init_done,
  output logic self_active,
  output logic ras_n,
  output logic cas_n
);
  logic owed, accepted, take, self_exit;

  assign refresh_req = init_done && !busy && (owed || self_req);
  assign accepted    = refresh_req && refresh_gnt;
  assign take        = accepted && !self_req;

  rf_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC), .BL_MAX(BL_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .take(take),
    .clear(self_exit), .owed(owed)
  );

  rf_cycle_fsm #(.PWRUP_CYC(PWRUP_CYC), .INIT_CNT(INIT_CNT), .T_CSR(T_CSR),
                 .T_RAS(T_RAS), .T_RP(T_RP), .T_SELF(T_SELF), .T_RPS(T_RPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accepted), .self_req(self_req),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .done(refresh_done),
    .init_done(init_done), .self_active(self_active), .self_exit(self_exit)
  );

  a_r2_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |=> !refresh_done);
  a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> busy);
  a_r9_self_low: assert property (@(posedge clk) disable iff (!rst_n)
    self_active |-> (!ras_n && !cas_n));
  a_r6_stray_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_gnt && !refresh_req && !busy) |=> !busy);
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int PW = 20, NI = 8, INTV = 200, BLM = 8;
  localparam int TCSR = 2, TRAS = 3, TRP = 2, TSELF = 6, TRPS = 3;

  logic clk = 1'b0, rst_n = 1'b0, self_req = 1'b0, refresh_gnt = 1'b0;
  logic refresh_req, refresh_done, busy, init_done, self_active, ras_n, cas_n;
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(.PWRUP_CYC(PW), .INIT_CNT(NI), .INTERVAL_CYC(INTV), .BL_MAX(BLM),
                     .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_SELF(TSELF), .T_RPS(TRPS)) uut (
    .clk(clk), .rst_n(rst_n), .self_req(self_req), .refresh_gnt(refresh_gnt),
    .refresh_req(refresh_req), .refresh_done(refresh_done), .busy(busy),
    .init_done(init_done), .self_active(self_active), .ras_n(ras_n), .cas_n(cas_n));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=60000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req();
    int n = 0;
    while (!refresh_req && n < 5000) begin @(negedge clk); n++; end
  endtask

  // Grant one request after dly cycles and measure the phases of the cycle.
  task automatic grant_cycle(input int dly, output int cw, output int rw, output int pw,
                             output bit dn, output bit held, output bit bz);
    wait_req();
    held = 1'b1;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      if (!refresh_req) held = 1'b0;
    end
    refresh_gnt = 1'b1;
    @(negedge clk);
    refresh_gnt = 1'b0;
    bz = busy;
    cw = 0; rw = 0; pw = 0;
    while (!cas_n && ras_n && cw < 100) begin cw++; @(negedge clk); end
    while (!ras_n && rw < 100) begin rw++; @(negedge clk); end
    while (busy && pw < 100) begin pw++; @(negedge clk); end
    dn = refresh_done;
    @(negedge clk);
    if (refresh_done) dn = 1'b0;
  endtask

  // grant delay, expected CAS lead, RAS low, precharge
  localparam int VEC [4][4] = '{'{0, TCSR, TRAS, TRP}, '{1, TCSR, TRAS, TRP},
                                '{4, TCSR, TRAS, TRP}, '{9, TCSR, TRAS, TRP}};

  initial begin
    int n, falls, cw, rw, pw, served;
    bit dn, held, bz, prev_ras, ok;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && !refresh_req && !init_done && busy, "R1 reset state",
        {ras_n, cas_n, refresh_req, init_done, busy}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    while (cas_n && n < 1000) begin n++; @(negedge clk); end
    chk(n >= PW - 1 && n <= PW, "R1 power-up wait", n, PW - 1);

    // R2: initialization burst without grants
    falls = 0; prev_ras = 1'b1; ok = 1'b1; n = 0;
    while (!init_done && n < 1000) begin
      if (prev_ras && !ras_n) falls++;
      if (refresh_req) ok = 1'b0;
      prev_ras = ras_n;
      n++;
      @(negedge clk);
    end
    chk(falls == NI, "R2 init cycle count", falls, NI);
    chk(ok, "R2 no request before init_done", ok, 1);

    // R5 first interval, with R6 stray grant inside it
    n = 0; ok = 1'b1;
    while (!refresh_req && n < 1000) begin
      if (n == 5) refresh_gnt = 1'b1;
      @(negedge clk);
      refresh_gnt = 1'b0;
      if (n >= 5 && n < 9 && (busy || !cas_n || !ras_n)) ok = 1'b0;
      n++;
    end
    chk(ok, "R6 stray grant ignored", ok, 1);
    chk(n >= INTV - 1 && n <= INTV, "R5 interval to first request", n, INTV - 1);

    // Table walk: grant delays, phase widths (R3, R4, R5, R8)
    foreach (VEC[i]) begin
      grant_cycle(VEC[i][0], cw, rw, pw, dn, held, bz);
      chk(held, "R5 request held until grant", held, 1);
      chk(bz, "R8 busy after grant", bz, 1);
      chk(cw == VEC[i][1], "R3 CAS lead", cw, VEC[i][1]);
      chk(rw == VEC[i][2], "R4 RAS low width", rw, VEC[i][2]);
      chk(pw == VEC[i][3], "R4 precharge width", pw, VEC[i][3]);
      chk(dn, "R8 done single pulse", dn, 1);
      chk(!refresh_req, "R7 request drops when nothing owed", refresh_req, 0);
    end

    // R7: backlog of three
    wait_req();
    repeat (2 * INTV + 10) @(negedge clk);
    served = 0;
    for (int k = 0; k < 3; k++) begin
      chk(refresh_req, "R7 backlog still owed", refresh_req, 1);
      grant_cycle(0, cw, rw, pw, dn, held, bz);
      served++;
    end
    chk(!refresh_req, "R7 backlog drained after three", refresh_req, 0);

    // R7: saturation at BL_MAX
    wait_req();
    repeat (10 * INTV + 10) @(negedge clk);
    served = 0;
    while (refresh_req && served < 12) begin
      grant_cycle(0, cw, rw, pw, dn, held, bz);
      served++;
    end
    chk(served == BLM, "R7 backlog saturates", served, BLM);

    // R9/R10: long self-refresh with a refresh owed beforehand
    wait_req();
    self_req = 1'b1;
    refresh_gnt = 1'b1;
    @(negedge clk);
    refresh_gnt = 1'b0;
    cw = 0; rw = 0; pw = 0; ok = 1'b1;
    while (!cas_n && ras_n && cw < 100) begin cw++; @(negedge clk); end
    while (!ras_n && rw < 100) begin
      if (!self_active) ok = 1'b0;
      rw++;
      if (rw == 12) self_req = 1'b0;
      @(negedge clk);
    end
    while (busy && pw < 100) begin pw++; @(negedge clk); end
    chk(cw == TCSR, "R9 CAS leads into self-refresh", cw, TCSR);
    chk(ok, "R9 self_active while held", ok, 1);
    chk(rw == 12, "R9 held while requested", rw, 12);
    chk(pw == TRPS, "R10 exit precharge", pw, TRPS);
    chk(refresh_done, "R10 done after exit", refresh_done, 1);
    @(negedge clk);
    chk(!refresh_req, "R10 owed refreshes cleared", refresh_req, 0);

    // R9: request dropped early, minimum hold still applies
    self_req = 1'b1;
    wait_req();
    refresh_gnt = 1'b1;
    @(negedge clk);
    refresh_gnt = 1'b0;
    self_req = 1'b0;
    cw = 0; rw = 0; pw = 0;
    while (!cas_n && ras_n && cw < 100) begin cw++; @(negedge clk); end
    while (!ras_n && rw < 100) begin rw++; @(negedge clk); end
    while (busy && pw < 100) begin pw++; @(negedge clk); end
    chk(rw == TSELF, "R9 minimum self-refresh hold", rw, TSELF);
    chk(pw == TRPS, "R10 exit precharge after short stay", pw, TRPS);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule